// File: doc/BRIEF.md
# Staged Reset and Startup Sequencer

This block brings a small processor system out of power-up and into code execution through a chain of separately timed hold phases. Each phase has its own delay, and the phases are always taken in the same order. The inputs are two supply comparator flags (power-on level reached, brown-out level reached), a clock-ok flag from the oscillator, an enable for the power-up timer phase, and an enable for the clock monitor. Every delay is measured in strobes of a free-running low-speed timebase (`tick`). Each delay length is a parameter.

The sequence runs as follows. A power-on hold comes first. A brown-out hold follows, then an optional power-up timer hold. System reset is released after that, which turns the oscillator on. The oscillator wait then times three sub-delays in turn: start delay, start-up count and lock time. When it ends, a one-cycle run strobe releases the CPU at the reset vector. While the monitor enable is set, a monitor-enable output rises a set delay later. Losing the brown-out flag sends the sequencer back to the brown-out hold. Losing the power-on flag sends it back to the very start. All outputs are registered.

Top module: `reset_startup_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `phase` is 0 and `por_hold`, `bor_hold` and `sys_rst` are 1. `osc_en`, `cpu_run` and `mon_en` are 0.
- R2: The sequencer stays in the power-on phase until `por_ok` is high and POR_TICKS strobes of `tick` have been counted with `por_ok` high. Clock cycles with `tick` low add nothing to the count, and `por_ok` low clears the count.
- R3: The brown-out phase (`bor_hold`=1, `por_hold`=0) lasts until BOR_TICKS strobes have been counted with `bor_ok` high. Any cycle with `bor_ok` low clears that count.
- R4: With `pwrt_en`=1, a power-up timer phase (`sys_rst`=1, `bor_hold`=0) of PWRT_TICKS strobes follows the brown-out phase. With `pwrt_en`=0 that phase is skipped, and the brown-out phase goes straight to the oscillator phase.
- R5: `sys_rst` falls and `osc_en` rises on the same clock edge, on entry to the oscillator phase. `osc_en` is never 1 while `sys_rst` is 1.
- R6: The oscillator phase times OSCD_TICKS, then OST_TICKS, then LOCK_TICKS strobes. It leaves to run only when all three have elapsed and `osc_ok` is high, and it waits for `osc_ok` as long as that flag is low.
- R7: On entry to the run phase, `cpu_run` is 1 for exactly one cycle, with `reset_vec` equal to RESET_VEC (default 0x000000).
- R8: With `fscm_en`=1, `mon_en` rises after MON_TICKS strobes have been counted in the run phase. With `fscm_en`=0, `mon_en` stays 0.
- R9: If `bor_ok` is low while `por_ok` is high in the timer, oscillator or run phase, the next phase is brown-out. `sys_rst` is then 1, `osc_en` and `mon_en` are 0, and the brown-out delay counts again from zero.
- R10: If `por_ok` is low in any phase, the next phase is power-on.
- R11: `phase` is encoded as POR=0, BOR=1, PWRT=2, OSC=3, RUN=4. A phase only moves forward by one step, or from BOR to OSC, or back to 0 or 1. When `tick` is high every cycle, a delay of N strobes keeps its phase for N+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle per count |
| por_ok | input | 1 | Supply above the power-on level |
| bor_ok | input | 1 | Supply above the brown-out level |
| osc_ok | input | 1 | Oscillator reports a usable clock |
| pwrt_en | input | 1 | Include the power-up timer phase |
| fscm_en | input | 1 | Enable the clock monitor release |
| por_hold | output | 1 | Power-on hold active |
| bor_hold | output | 1 | Brown-out hold active (also set during power-on) |
| sys_rst | output | 1 | System reset |
| osc_en | output | 1 | Oscillator enable |
| cpu_run | output | 1 | One-cycle strobe releasing the CPU |
| reset_vec | output | ADDR_W | Fetch address presented with `cpu_run` |
| mon_en | output | 1 | Clock monitor enable |
| phase | output | 3 | Current phase code |

## Verification
The assertions assume that the two supply flags are synchronous to `clk` and that `rst` is high on the first edge. They also assume that `tick` is a single-cycle strobe, so that a count of N strobes maps to N cycles with `tick` high. The stimulus drives every input one time unit after a rising edge. It keeps `tick` either held high or held low for whole stretches, so that phase lengths can be predicted exactly as N+1 cycles. It drops the supply flags only at chosen phases, so that each return path is entered from a known state.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [2:0] {
    PH_POR  = 3'd0,
    PH_BOR  = 3'd1,
    PH_PWRT = 3'd2,
    PH_OSC  = 3'd3,
    PH_RUN  = 3'd4
  } phase_t;
endpackage

// File: rtl/rss_tick_timer.sv
module rss_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (tick && (cnt != limit))
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit);
endmodule

// File: rtl/rss_phase_ctrl.sv
module rss_phase_ctrl
  import rss_pkg::*;
#(
  parameter int POR_TICKS  = 16,
  parameter int BOR_TICKS  = 8,
  parameter int PWRT_TICKS = 64,
  parameter int OSCD_TICKS = 4,
  parameter int OST_TICKS  = 32,
  parameter int LOCK_TICKS = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   por_ok,
  input  logic   bor_ok,
  input  logic   osc_ok,
  input  logic   pwrt_en,
  output phase_t st,
  output phase_t st_nx
);
  localparam int M1   = (POR_TICKS > BOR_TICKS) ? POR_TICKS : BOR_TICKS;
  localparam int M2   = (M1 > PWRT_TICKS) ? M1 : PWRT_TICKS;
  localparam int M3   = (M2 > OSCD_TICKS) ? M2 : OSCD_TICKS;
  localparam int M4   = (M3 > OST_TICKS) ? M3 : OST_TICKS;
  localparam int TMAX = (M4 > LOCK_TICKS) ? M4 : LOCK_TICKS;
  localparam int CW   = (TMAX < 1) ? 1 : $clog2(TMAX + 1);

  logic [1:0]    sub, sub_nx;
  logic          hold_clr, tmr_clr, tmr_done;
  logic [CW-1:0] limit;

  always_comb begin
    unique case (st)
      PH_POR:  limit = CW'(POR_TICKS);
      PH_BOR:  limit = CW'(BOR_TICKS);
      PH_PWRT: limit = CW'(PWRT_TICKS);
      PH_OSC:  limit = (sub == 2'd0) ? CW'(OSCD_TICKS) :
                       (sub == 2'd1) ? CW'(OST_TICKS) : CW'(LOCK_TICKS);
      default: limit = '0;
    endcase
  end

  always_comb begin
    st_nx    = st;
    sub_nx   = sub;
    hold_clr = 1'b0;
    unique case (st)
      PH_POR: begin
        hold_clr = !por_ok;
        if (por_ok && tmr_done) st_nx = PH_BOR;
      end
      PH_BOR: begin
        hold_clr = !bor_ok;
        if (bor_ok && tmr_done) st_nx = pwrt_en ? PH_PWRT : PH_OSC;
      end
      PH_PWRT: if (tmr_done) st_nx = PH_OSC;
      PH_OSC: begin
        if (tmr_done) begin
          if (sub != 2'd2) sub_nx = sub + 2'd1;
          else if (osc_ok) st_nx = PH_RUN;
        end
      end
      default: st_nx = st;
    endcase
    if ((st == PH_PWRT || st == PH_OSC || st == PH_RUN) && !bor_ok) st_nx = PH_BOR;
    if (!por_ok) st_nx = PH_POR;
    if (st_nx != st) sub_nx = 2'd0;
  end

  assign tmr_clr = hold_clr || (st_nx != st) || (sub_nx != sub);

  rss_tick_timer #(.W(CW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .tick  (tick),
    .limit (limit),
    .done  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PH_POR;
      sub <= 2'd0;
    end else begin
      st  <= st_nx;
      sub <= sub_nx;
    end
  end
endmodule

// File: rtl/rss_out_reg.sv
module rss_out_reg
  import rss_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [63:0] RESET_VEC = 64'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            st,
  input  phase_t            st_nx,
  input  logic              fscm_en,
  input  logic              mon_done,
  output logic              por_hold,
  output logic              bor_hold,
  output logic              sys_rst,
  output logic              osc_en,
  output logic              cpu_run,
  output logic [ADDR_W-1:0] reset_vec,
  output logic              mon_en
);
  logic entering_run;
  assign entering_run = (st_nx == PH_RUN) && (st != PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      por_hold  <= 1'b1;
      bor_hold  <= 1'b1;
      sys_rst   <= 1'b1;
      osc_en    <= 1'b0;
      cpu_run   <= 1'b0;
      reset_vec <= '0;
      mon_en    <= 1'b0;
    end else begin
      por_hold  <= (st_nx == PH_POR);
      bor_hold  <= (st_nx == PH_POR) || (st_nx == PH_BOR);
      sys_rst   <= (st_nx == PH_POR) || (st_nx == PH_BOR) || (st_nx == PH_PWRT);
      osc_en    <= (st_nx == PH_OSC) || (st_nx == PH_RUN);
      cpu_run   <= entering_run;
      reset_vec <= entering_run ? RESET_VEC[ADDR_W-1:0] : '0;
      mon_en    <= (st == PH_RUN) && (st_nx == PH_RUN) && fscm_en && mon_done;
    end
  end
endmodule

// File: rtl/reset_startup_seq.sv
module reset_startup_seq
  import rss_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter logic [63:0] RESET_VEC  = 64'h0,
  parameter int          POR_TICKS  = 16,
  parameter int          BOR_TICKS  = 8,
  parameter int          PWRT_TICKS = 64,
  parameter int          OSCD_TICKS = 4,
  parameter int          OST_TICKS  = 32,
  parameter int          LOCK_TICKS = 8,
  parameter int          MON_TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              por_ok,
  input  logic              bor_ok,
  input  logic              osc_ok,
  input  logic              pwrt_en,
  input  logic              fscm_en,
  output logic              por_hold,
  output logic              bor_hold,
  output logic              sys_rst,
  output logic              osc_en,
  output logic              cpu_run,
  output logic [ADDR_W-1:0] reset_vec,
  output logic              mon_en,
  output logic [2:0]        phase
);
  localparam int MW = (MON_TICKS < 1) ? 1 : $clog2(MON_TICKS + 1);

  phase_t st, st_nx;
  logic   mon_clr, mon_done;

  rss_phase_ctrl #(
    .POR_TICKS (POR_TICKS),  .BOR_TICKS (BOR_TICKS), .PWRT_TICKS(PWRT_TICKS),
    .OSCD_TICKS(OSCD_TICKS), .OST_TICKS (OST_TICKS), .LOCK_TICKS(LOCK_TICKS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .por_ok(por_ok), .bor_ok(bor_ok),
    .osc_ok(osc_ok), .pwrt_en(pwrt_en), .st(st), .st_nx(st_nx)
  );

  assign mon_clr = (st != PH_RUN) || !fscm_en;

  rss_tick_timer #(.W(MW)) u_mon_tmr (
    .clk(clk), .rst(rst), .clr(mon_clr), .tick(tick),
    .limit(MW'(MON_TICKS)), .done(mon_done)
  );

  rss_out_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_out (
    .clk(clk), .rst(rst), .st(st), .st_nx(st_nx), .fscm_en(fscm_en),
    .mon_done(mon_done), .por_hold(por_hold), .bor_hold(bor_hold),
    .sys_rst(sys_rst), .osc_en(osc_en), .cpu_run(cpu_run),
    .reset_vec(reset_vec), .mon_en(mon_en)
  );

  assign phase = st;
endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
  parameter int          ADDR_W    = 24,
  parameter logic [63:0] RESET_VEC = 64'h0
) (
  input logic              clk,
  input logic              rst,
  input logic              por_ok,
  input logic              bor_ok,
  input logic              fscm_en,
  input logic              por_hold,
  input logic              sys_rst,
  input logic              osc_en,
  input logic              cpu_run,
  input logic [ADDR_W-1:0] reset_vec,
  input logic              mon_en,
  input logic [2:0]        phase
);
  p_por_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0) |-> (por_hold && sys_rst));

  p_osc_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3) |-> (osc_en && !sys_rst));

  p_run_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_run |=> !cpu_run);

  p_run_vec_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_run |-> (reset_vec == RESET_VEC[ADDR_W-1:0]));

  p_mon_gate_r8: assert property (@(posedge clk) disable iff (rst)
    mon_en |-> ((phase == 3'd4) && $past(fscm_en)));

  p_bor_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (por_ok && !bor_ok && (phase >= 3'd2)) |=> (phase == 3'd1));

  p_por_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !por_ok |=> (phase == 3'd0));

  p_phase_order_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase) |-> ((phase == 3'd0) || (phase == 3'd1) ||
                         (phase == $past(phase) + 3'd1) ||
                         ((phase == 3'd3) && ($past(phase) == 3'd1))));
endmodule

bind reset_startup_seq rss_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_rss_chk (
  .clk(clk), .rst(rst), .por_ok(por_ok), .bor_ok(bor_ok), .fscm_en(fscm_en),
  .por_hold(por_hold), .sys_rst(sys_rst), .osc_en(osc_en), .cpu_run(cpu_run),
  .reset_vec(reset_vec), .mon_en(mon_en), .phase(phase)
);

// File: tb/reset_startup_seq_test.sv
`timescale 1ns/1ps
module reset_startup_seq_test;
  localparam int T_POR = 3, T_BOR = 2, T_PWRT = 4, T_OSCD = 1, T_OST = 2, T_LOCK = 1, T_MON = 3;
  localparam int OSC_CYC = (T_OSCD + 1) + (T_OST + 1) + (T_LOCK + 1);
  localparam logic [1:0] CFG_TAB [4] = '{2'b11, 2'b01, 2'b10, 2'b00}; // {pwrt_en, fscm_en}

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b1, por_ok = 1'b1, bor_ok = 1'b1, osc_ok = 1'b1;
  logic pwrt_en = 1'b1, fscm_en = 1'b1;
  logic por_hold, bor_hold, sys_rst, osc_en, cpu_run, mon_en;
  logic [23:0] reset_vec;
  logic [2:0]  phase;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  reset_startup_seq #(
    .POR_TICKS(T_POR), .BOR_TICKS(T_BOR), .PWRT_TICKS(T_PWRT), .OSCD_TICKS(T_OSCD),
    .OST_TICKS(T_OST), .LOCK_TICKS(T_LOCK), .MON_TICKS(T_MON)
  ) uut (
    .clk(clk), .rst(rst), .tick(tick), .por_ok(por_ok), .bor_ok(bor_ok), .osc_ok(osc_ok),
    .pwrt_en(pwrt_en), .fscm_en(fscm_en), .por_hold(por_hold), .bor_hold(bor_hold),
    .sys_rst(sys_rst), .osc_en(osc_en), .cpu_run(cpu_run), .reset_vec(reset_vec),
    .mon_en(mon_en), .phase(phase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic measure(output int n);
    logic [2:0] from;
    from = phase;
    n = 0;
    while (phase == from && n < 200) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic start(input logic pw, input logic fs, input logic ok);
    @(posedge clk); #1;
    rst = 1'b1; tick = 1'b1; por_ok = 1'b1; bor_ok = 1'b1;
    osc_ok = ok; pwrt_en = pw; fscm_en = fs;
    step(2);
    rst = 1'b0;
  endtask

  task automatic goto_phase(input logic [2:0] target);
    for (int i = 0; i < 100 && phase != target; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // Table of configurations walked by one loop
    foreach (CFG_TAB[k]) begin
      start(CFG_TAB[k][1], CFG_TAB[k][0], 1'b1);
      chk("R1 reset phase", phase, 0);
      chk("R1 reset holds", {por_hold, bor_hold, sys_rst, osc_en, cpu_run, mon_en}, 6'b111000);
      measure(n); chk("R2 por length", n, T_POR + 1);
      chk("R3 bor entry phase", phase, 1);
      chk("R3 bor outputs", {por_hold, bor_hold, sys_rst}, 3'b011);
      measure(n); chk("R3 bor length", n, T_BOR + 1);
      if (CFG_TAB[k][1]) begin
        chk("R4 pwrt entry phase", phase, 2);
        chk("R4 pwrt outputs", {bor_hold, sys_rst, osc_en}, 3'b010);
        measure(n); chk("R4 pwrt length", n, T_PWRT + 1);
      end
      chk("R4 osc follows", phase, 3);
      chk("R5 osc outputs", {sys_rst, osc_en}, 2'b01);
      measure(n); chk("R6 osc length", n, OSC_CYC);
      chk("R11 run code", phase, 4);
      chk("R7 run strobe", cpu_run, 1);
      chk("R7 reset vector", int'(reset_vec), 0);
      step(1);
      chk("R7 strobe single", cpu_run, 0);
      n = 1;
      while (!mon_en && n < 20) begin step(1); n++; end
      if (CFG_TAB[k][0]) chk("R8 monitor delay", n, T_MON + 1);
      else chk("R8 monitor disabled", mon_en, 0);
    end

    // R2: no strobes, no progress; por_ok low keeps power-on phase
    start(1'b1, 1'b1, 1'b1);
    tick = 1'b0;
    step(20); chk("R2 idle tick holds", phase, 0);
    tick = 1'b1; por_ok = 1'b0;
    step(10); chk("R2 por_ok low holds", phase, 0);
    por_ok = 1'b1;
    measure(n); chk("R2 por restart length", n, T_POR + 1);

    // R3: bor_ok low holds brown-out phase
    start(1'b1, 1'b1, 1'b1);
    bor_ok = 1'b0;
    goto_phase(3'd1);
    step(10); chk("R3 bor_ok low holds", phase, 1);
    bor_ok = 1'b1;
    measure(n); chk("R3 bor length after flag", n, T_BOR + 1);

    // R6: osc_ok low stalls the oscillator phase
    start(1'b0, 1'b1, 1'b0);
    goto_phase(3'd3);
    step(20); chk("R6 waits for osc_ok", phase, 3);
    osc_ok = 1'b1;
    step(1); chk("R6 leaves on osc_ok", phase, 4);
    chk("R7 strobe after wait", cpu_run, 1);

    // R9: brown-out in run
    start(1'b1, 1'b1, 1'b1);
    goto_phase(3'd4);
    step(T_MON + 2);
    chk("R8 monitor on before drop", mon_en, 1);
    bor_ok = 1'b0;
    step(1);
    chk("R9 back to bor", phase, 1);
    chk("R9 outputs", {sys_rst, osc_en, mon_en}, 3'b100);
    bor_ok = 1'b1;
    measure(n); chk("R9 bor restart length", n, T_BOR + 1);

    // R10: power-on flag loss during oscillator phase
    start(1'b1, 1'b1, 1'b1);
    goto_phase(3'd3);
    por_ok = 1'b0;
    step(1);
    chk("R10 back to por", phase, 0);
    chk("R10 holds", {por_hold, sys_rst, osc_en}, 3'b110);
    por_ok = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule